// File: doc/BRIEF.md
# Per-Pin GPIO Drive Source Selector

This block decides, pin by pin, which agent drives each of 24 general-purpose pins arranged as two banks of twelve. Each pin may be driven by a processor software path, a management software path (whose level and enable come from two registers inside this block), a user application, one of four radio state outputs (two radio slots with two channels each), or the serial-peripheral drive of either slot. Every source provides its own output value and output enable for every pin. The chosen pair is forwarded to the pad.

The selection for a pin is not a single field. It is a small decision tree read from several 32-bit configuration registers on a plain read/write bus. Every register stores bank 0 in its low half and bank 1 in its high half. A read-only register returns the pad levels after a two-stage synchronizer, using the same packing.

Top module: `gpio_src_mux`

## Requirements
- R1: In every configuration register, bank 0 pin n is bit n (bits 11:0) and bank 1 pin n is bit 16+n (bits 27:16). Bits 15:12 and 31:28 always read as zero, and writing them has no effect.
- R2: The writable registers sit at these offsets: owner 0x00, management enable 0x04, management level 0x0C, radio-path enable 0x10, slot select 0x14, peripheral select 0x18, peripheral override 0x1C, processor select 0x20 and channel select 0x24. A read of any other offset returns zero.
- R3: When a pin's radio-path bit is 1 and its override bit is 1, the pin takes the serial-peripheral output and enable of the slot named by its peripheral-select bit.
- R4: When a pin's radio-path bit is 1 and its override bit is 0, the pin takes the radio state output and enable at index slot*2+channel. The slot comes from the slot-select bit and the channel from the channel-select bit.
- R5: When a pin's radio-path bit is 0, its owner bit is 1 and its processor-select bit is 1, the pin takes the processor path's output and enable.
- R6: When a pin's radio-path bit is 0, its owner bit is 1 and its processor-select bit is 0, the pin takes the management path. Its level is the management level bit and its enable is the management enable bit.
- R7: When a pin's radio-path bit and owner bit are both 0, the pin takes the user application's output and enable.
- R8: Offset 0x08 returns the pad levels with R1 packing, two clock edges after they are sampled. Writes to 0x08 have no effect.
- R9: After reset, every register reads zero and every pin is driven by the user application.
- R10: Pad vector index b*12+n corresponds to register bit b*16+n, for bank b and pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ps_out | input | 24 | Processor path output level per pin |
| ps_oe | input | 24 | Processor path output enable per pin |
| app_out | input | 24 | User application output level per pin |
| app_oe | input | 24 | User application output enable per pin |
| rf_out | input | 4x24 | Radio state outputs, index slot*2+channel |
| rf_oe | input | 4x24 | Radio state output enables |
| spi_out | input | 2x24 | Serial-peripheral output per slot |
| spi_oe | input | 2x24 | Serial-peripheral output enable per slot |
| pad_in | input | 24 | Pad input levels |
| pad_out | output | 24 | Selected output level per pin |
| pad_oe | output | 24 | Selected output enable per pin |

## Verification
The hard part is showing that every pin position can reach every one of the nine sources, and that bits outside the active branch of the tree have no influence. The bench runs nine passes. In each pass every pin gets a source code offset by its own index, so across the passes each pin visits every source. Select bits that the chosen branch does not use are filled with a pattern that varies by pin. Source vectors change from pass to pass, so a mis-wired index or bank offset shows up as a wrong level or enable.

// File: rtl/gpio_src_mux.sv
module gpio_src_mux #(
  parameter int PINS   = 12,
  parameter int STRIDE = 16,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int NP    = 2 * PINS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NP-1:0]          ps_out,
  input  logic [NP-1:0]          ps_oe,
  input  logic [NP-1:0]          app_out,
  input  logic [NP-1:0]          app_oe,
  input  logic [3:0][NP-1:0]     rf_out,
  input  logic [3:0][NP-1:0]     rf_oe,
  input  logic [1:0][NP-1:0]     spi_out,
  input  logic [1:0][NP-1:0]     spi_oe,
  input  logic [NP-1:0]          pad_in,
  output logic [NP-1:0]          pad_out,
  output logic [NP-1:0]          pad_oe
);

  localparam logic [AW-1:0] A_OWNER = AW'('h00);
  localparam logic [AW-1:0] A_MEN   = AW'('h04);
  localparam logic [AW-1:0] A_LEVEL = AW'('h08);
  localparam logic [AW-1:0] A_MLVL  = AW'('h0C);
  localparam logic [AW-1:0] A_RADIO = AW'('h10);
  localparam logic [AW-1:0] A_SLOT  = AW'('h14);
  localparam logic [AW-1:0] A_PSEL  = AW'('h18);
  localparam logic [AW-1:0] A_OVR   = AW'('h1C);
  localparam logic [AW-1:0] A_CPU   = AW'('h20);
  localparam logic [AW-1:0] A_CHAN  = AW'('h24);

  function automatic logic [DW-1:0] pack(input logic [NP-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < NP; i++) r[(i / PINS) * STRIDE + (i % PINS)] = v[i];
    return r;
  endfunction

  localparam logic [DW-1:0] USED = pack({NP{1'b1}});

  logic [DW-1:0] owner, men, mlvl, radio, slot, psel, ovr, cpu, chan;
  logic [NP-1:0] sync1, sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= '0; men <= '0; mlvl <= '0; radio <= '0; slot <= '0;
      psel  <= '0; ovr <= '0; cpu  <= '0; chan  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OWNER: owner <= bus_wdata & USED;
        A_MEN:   men   <= bus_wdata & USED;
        A_MLVL:  mlvl  <= bus_wdata & USED;
        A_RADIO: radio <= bus_wdata & USED;
        A_SLOT:  slot  <= bus_wdata & USED;
        A_PSEL:  psel  <= bus_wdata & USED;
        A_OVR:   ovr   <= bus_wdata & USED;
        A_CPU:   cpu   <= bus_wdata & USED;
        A_CHAN:  chan  <= bus_wdata & USED;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_OWNER: bus_rdata = owner;
      A_MEN:   bus_rdata = men;
      A_LEVEL: bus_rdata = pack(sync2);
      A_MLVL:  bus_rdata = mlvl;
      A_RADIO: bus_rdata = radio;
      A_SLOT:  bus_rdata = slot;
      A_PSEL:  bus_rdata = psel;
      A_OVR:   bus_rdata = ovr;
      A_CPU:   bus_rdata = cpu;
      A_CHAN:  bus_rdata = chan;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    localparam int B = (i / PINS) * STRIDE + (i % PINS);
    logic       o, e;
    logic [1:0] rf_idx;
    assign rf_idx = {slot[B], chan[B]};
    always_comb begin
      if (radio[B]) begin
        if (ovr[B]) begin
          o = spi_out[psel[B]][i];
          e = spi_oe[psel[B]][i];
        end else begin
          o = rf_out[rf_idx][i];
          e = rf_oe[rf_idx][i];
        end
      end else if (owner[B]) begin
        if (cpu[B]) begin
          o = ps_out[i];
          e = ps_oe[i];
        end else begin
          o = mlvl[B];
          e = men[B];
        end
      end else begin
        o = app_out[i];
        e = app_oe[i];
      end
    end
    assign pad_out[i] = o;
    assign pad_oe[i]  = e;
  end

endmodule

// File: rtl/gpio_src_mux_chk.sv
module gpio_src_mux_chk #(
  parameter int PINS   = 12,
  parameter int STRIDE = 16,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int NP    = 2 * PINS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic [NP-1:0]      pad_in,
  input logic [NP-1:0]      pad_oe,
  input logic [1:0][NP-1:0] spi_oe,
  input logic [DW-1:0]      radio,
  input logic [DW-1:0]      ovr,
  input logic [DW-1:0]      psel
);

  function automatic logic [DW-1:0] pk(input logic [NP-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < NP; i++) r[(i / PINS) * STRIDE + (i % PINS)] = v[i];
    return r;
  endfunction

  localparam logic [DW-1:0] MASK = pk({NP{1'b1}});

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic wr_ok;
  assign wr_ok = bus_we && bus_addr <= AW'('h24) && bus_addr[1:0] == 2'b00 && bus_addr != AW'('h08);

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~MASK) == '0);

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (bus_addr != $past(bus_addr)) || (bus_rdata == ($past(bus_wdata) & MASK)));

  // R8
  level_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && bus_addr == AW'('h08)) |-> bus_rdata == pk($past(pad_in, 2)));

  for (genvar i = 0; i < NP; i++) begin : g_c
    localparam int B = (i / PINS) * STRIDE + (i % PINS);
    // R3
    spi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (radio[B] && ovr[B]) |-> pad_oe[i] == spi_oe[psel[B]][i]);
  end

endmodule

bind gpio_src_mux gpio_src_mux_chk #(.PINS(PINS), .STRIDE(STRIDE), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_oe(pad_oe), .spi_oe(spi_oe), .radio(radio), .ovr(ovr), .psel(psel)
);

// File: tb/test_gpio_src_mux.sv
module test_gpio_src_mux;
  localparam int NP = 24;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NP-1:0] ps_out = 0, ps_oe = 0, app_out = 0, app_oe = 0, pad_in = 0, pad_out, pad_oe;
  logic [3:0][NP-1:0] rf_out = '0, rf_oe = '0;
  logic [1:0][NP-1:0] spi_out = '0, spi_oe = '0;

  gpio_src_mux i_gpio_src_mux (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ps_out(ps_out), .ps_oe(ps_oe),
    .app_out(app_out), .app_oe(app_oe), .rf_out(rf_out), .rf_oe(rf_oe),
    .spi_out(spi_out), .spi_oe(spi_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(logic [NP-1:0] v);
    logic [31:0] r = 0;
    for (int i = 0; i < NP; i++) r[(i / 12) * 16 + (i % 12)] = v[i];
    return r;
  endfunction

  function automatic logic [NP-1:0] mix(int seed, int k);
    return NP'((seed * (k + 3) + k * 977 + seed / 7) & 32'hFFFFFF);
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] wofs [9] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
    app_out = 24'h3C5A96; app_oe = 24'hC3A569;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R9: reset state
    for (int a = 0; a <= 8'h24; a += 4) begin
      rd(8'(a), d);
      chk($sformatf("R9 reset read @%0h", a), d, 0);
    end
    chk("R9 reset pad_out", 32'(pad_out), 32'(app_out));
    chk("R9 reset pad_oe", 32'(pad_oe), 32'(app_oe));

    // R1 R2: packing, reserved bits, offsets
    foreach (wofs[j]) begin
      wr(wofs[j], 32'hFFFF_FFFF);
      rd(wofs[j], d);
      chk($sformatf("R1 reserved @%0h", wofs[j]), d, 32'h0FFF_0FFF);
      wr(wofs[j], 32'hA5C3_5A3C ^ (32'(j) * 32'h0101_0101));
      rd(wofs[j], d);
      chk($sformatf("R2 readback @%0h", wofs[j]), d, (32'hA5C3_5A3C ^ (32'(j) * 32'h0101_0101)) & 32'h0FFF_0FFF);
    end
    foreach (wofs[j]) wr(wofs[j], 0);
    rd(8'h28, d); chk("R2 unmapped 0x28", d, 0);
    rd(8'h3C, d); chk("R2 unmapped 0x3C", d, 0);
    rd(8'h02, d); chk("R2 unmapped 0x02", d, 0);

    // R8: level register is read-only
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R8 write ignored", d, 0);

    // R8: synchronizer latency
    for (int t = 0; t < 8; t++) begin
      logic [NP-1:0] prev, v;
      prev = pad_in;
      v = mix(24'hB6D35A + t * 311, t);
      @(negedge clk); bus_addr = 8'h08; pad_in = v;
      @(negedge clk); #1 chk($sformatf("R8 one edge t=%0d", t), bus_rdata, pack(prev));
      @(negedge clk); #1 chk($sformatf("R8 two edges t=%0d", t), bus_rdata, pack(v));
    end

    // R3..R7, R10: every pin through every source
    for (int k = 0; k < 9; k++) begin
      logic [NP-1:0] vo, ve, mo, me, sow, sen, ssrc, sslot, ssel, sovr, scpu, schan;
      ps_out = mix(1111, k); ps_oe = mix(2222, k);
      app_out = mix(3333, k); app_oe = mix(4444, k);
      for (int s = 0; s < 4; s++) begin
        rf_out[s] = mix(5000 + 17 * s, k); rf_oe[s] = mix(6000 + 23 * s, k);
      end
      for (int s = 0; s < 2; s++) begin
        spi_out[s] = mix(7000 + 29 * s, k); spi_oe[s] = mix(8000 + 31 * s, k);
      end
      mo = mix(9101, k); me = mix(9202, k);
      for (int p = 0; p < NP; p++) begin
        int c; logic j;
        c = (p + k) % 9;
        j = 1'(((p * 5 + k) >> 1) & 1);
        sow[p] = (c <= 1) ? 1'b1 : (c == 2 ? 1'b0 : j);
        scpu[p] = (c == 0) ? 1'b1 : (c == 1 ? 1'b0 : ~j);
        ssrc[p] = (c >= 3);
        sovr[p] = (c >= 7) ? 1'b1 : (c >= 3 ? 1'b0 : j);
        sslot[p] = (c >= 3 && c <= 6) ? 1'((c - 3) >> 1) : ~j;
        schan[p] = (c >= 3 && c <= 6) ? 1'((c - 3) & 1) : j;
        ssel[p] = (c >= 7) ? 1'(c - 7) : j;
      end
      wr(8'h00, pack(sow)); wr(8'h04, pack(me)); wr(8'h0C, pack(mo));
      wr(8'h10, pack(ssrc)); wr(8'h14, pack(sslot)); wr(8'h18, pack(ssel));
      wr(8'h1C, pack(sovr)); wr(8'h20, pack(scpu)); wr(8'h24, pack(schan));
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        int c; string rq;
        c = (p + k) % 9;
        case (c)
          0: begin vo[p] = ps_out[p]; ve[p] = ps_oe[p]; rq = "R5"; end
          1: begin vo[p] = mo[p]; ve[p] = me[p]; rq = "R6"; end
          2: begin vo[p] = app_out[p]; ve[p] = app_oe[p]; rq = "R7"; end
          7, 8: begin vo[p] = spi_out[c - 7][p]; ve[p] = spi_oe[c - 7][p]; rq = "R3"; end
          default: begin vo[p] = rf_out[c - 3][p]; ve[p] = rf_oe[c - 3][p]; rq = "R4"; end
        endcase
        chk($sformatf("%s R10 out pin=%0d k=%0d", rq, p, k), 32'(pad_out[p]), 32'(vo[p]));
        chk($sformatf("%s R10 oe pin=%0d k=%0d", rq, p, k), 32'(pad_oe[p]), 32'(ve[p]));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule